// File: doc/BRIEF.md
# Pipeline Interlock and Stall Controller

This block is the hazard control unit of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that has no forwarding paths. Each cycle it receives the decoded fields of the instruction sitting in decode. These are its two source register numbers with their use flags, its destination register with a write flag, and a flag marking it as a conditional branch. From them it drives the hold, bubble and squash controls of the front end. It keeps its own record of which older instructions still in execute or memory will write a register. It fills that record only from instructions it lets leave decode, so no separate pipeline status is needed.

The register file writes in the first half of a cycle and reads in the second half. A producer that has reached writeback therefore never blocks a consumer in decode. A producer in execute or memory always does, because there is nothing to forward its result. Conditional branches are not predicted. Once a branch leaves decode, fetch is frozen and every fetched slot is squashed until the branch has evaluated in execute. On that cycle the unit tells the program counter logic whether to load the taken target or the fall-through address.

The sequencer has two states. In `ST_FLOW` each cycle takes one of four actions: `ACT_IDLE` (decode empty), `ACT_ADVANCE` (instruction issues), `ACT_DATA_STALL` (source still being produced) or `ACT_BR_ISSUE` (hazard-free branch leaves decode). `ACT_BR_ISSUE` moves the state to `ST_RESOLVE`. Every other action stays in `ST_FLOW`. `ST_RESOLVE` always performs `ACT_BR_RESOLVE` and returns to `ST_FLOW` on the next edge. Reset forces `ST_FLOW`.

Top module: `hz_interlock`

## Requirements
- R1: While `rst` is high at a clock edge, all five outputs are 0. The same edge empties the record of in-flight writers, so an instruction that issued before reset never causes a stall afterwards.
- R2: When a valid decode instruction uses a source register that is also the destination of a valid, writing, older instruction now in execute or memory, then `pc_hold`, `ifid_hold` and `idex_bubble` are 1 and `fetch_squash` is 0 in that cycle.
- R3: A producer that is three or more issue slots ahead of its consumer (it has reached writeback) causes no stall.
- R4: A consumer that directly follows its producer stalls for exactly 2 cycles. With one independent instruction between them it stalls for exactly 1 cycle. A stall never lasts more than 2 consecutive cycles.
- R5: Register number 0 never causes a stall, whether it is a source or a destination.
- R6: A source field whose use flag is 0 never causes a stall, whatever register number it holds.
- R7: A valid branch in decode with no data hazard gives `pc_hold`=1 and `fetch_squash`=1, with `ifid_hold`=0 and `idex_bubble`=0, in that cycle.
- R8: In the cycle after a branch issues (branch in execute), `pc_hold`=1, `fetch_squash`=1 and `redirect_take` equals `ex_taken`. The decode inputs are ignored in that cycle and are never recorded as a writer. In every other cycle `redirect_take` is 0.
- R9: A branch in decode with a data hazard on its source is handled as a data stall (R2), with `fetch_squash`=0, until the hazard clears. The freeze of R7 starts only after that.
- R10: With `id_valid`=0 outside the branch-resolve cycle, all outputs are 0 and nothing is recorded.
- R11: In the cycle after branch resolution, a non-dependent instruction in decode sees all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src_a | input | REG_W | First source register number |
| id_use_a | input | 1 | First source is read |
| id_src_b | input | REG_W | Second source register number |
| id_use_b | input | 1 | Second source is read |
| id_dst | input | REG_W | Destination register number |
| id_wr | input | 1 | Instruction writes its destination |
| id_branch | input | 1 | Instruction is a conditional branch |
| ex_taken | input | 1 | Branch outcome from execute, meaningful in the resolve cycle |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |
| fetch_squash | output | 1 | Mark the slot entering fetch/decode as empty |
| redirect_take | output | 1 | Load the branch target into the program counter |

## Verification
Every output is a combinational function of the present decode inputs and of state captured at the previous edge. A stall or freeze is therefore due in the same cycle as the decode stimulus that causes it. The branch-resolve controls are due exactly one edge after the branch issues, and the end of a stall is due two edges after the producer issues. The bench drives inputs 1 ns after a rising edge and samples all five outputs 4 ns later, before the next edge. It then advances its countdown model of in-flight writers and of the pending branch at that edge. It also counts bubble cycles per scenario to confirm the stall lengths.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic {
        ST_FLOW    = 1'b0,
        ST_RESOLVE = 1'b1
    } hz_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE       = 3'd0,
        ACT_ADVANCE    = 3'd1,
        ACT_DATA_STALL = 3'd2,
        ACT_BR_ISSUE   = 3'd3,
        ACT_BR_RESOLVE = 3'd4
    } hz_act_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
        logic fetch_squash;
        logic redirect_take;
    } hz_ctl_t;

endpackage

// File: rtl/hz_stage_track.sv
// Record of the destinations of issued instructions that have not yet
// reached the split-cycle write stage. Slot 0 is execute, the last slot
// is the stage just before writeback.
module hz_stage_track #(
    parameter int REG_W = 5,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [REG_W-1:0] push_dst,
    input  logic             push_wr,
    output logic [DEPTH-1:0] trk_v,
    output logic [REG_W-1:0] trk_dst [DEPTH]
);

    logic load_v;

    // Writes to register zero are dropped at entry.
    assign load_v = push && push_wr && (push_dst != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                trk_v[k]   <= 1'b0;
                trk_dst[k] <= '0;
            end
        end else begin
            trk_v[0]   <= load_v;
            trk_dst[0] <= load_v ? push_dst : '0;
            for (int k = 1; k < DEPTH; k++) begin
                trk_v[k]   <= trk_v[k-1];
                trk_dst[k] <= trk_dst[k-1];
            end
        end
    end

endmodule

// File: rtl/hz_dep_detect.sv
// Compares each used source register of the decode instruction with
// every recorded in-flight destination.
module hz_dep_detect #(
    parameter int REG_W   = 5,
    parameter int DEPTH   = 2,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_W-1:0]   src     [NUM_SRC],
    input  logic [NUM_SRC-1:0] use_src,
    input  logic [DEPTH-1:0]   trk_v,
    input  logic [REG_W-1:0]   trk_dst [DEPTH],
    output logic               hit
);

    logic [NUM_SRC-1:0] src_hit;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            logic [DEPTH-1:0] match;
            for (genvar k = 0; k < DEPTH; k++) begin : g_slot
                assign match[k] = trk_v[k] && (trk_dst[k] == src[s]);
            end
            assign src_hit[s] = use_src[s] && (src[s] != '0) && (|match);
        end
    endgenerate

    assign hit = |src_hit;

endmodule

// File: rtl/hz_seq.sv
// Sequencer: chooses the action of the cycle and drives the front-end
// controls from it.
module hz_seq
    import hz_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    id_valid,
    input  logic    id_branch,
    input  logic    dep_hit,
    input  logic    ex_taken,
    output hz_ctl_t ctl,
    output logic    issue
);

    hz_state_e state_q;
    hz_state_e state_d;
    hz_act_e   act;

    // Action of the current cycle.
    always_comb begin
        act = ACT_IDLE;
        unique case (state_q)
            ST_FLOW: begin
                if (!id_valid) begin
                    act = ACT_IDLE;
                end else if (dep_hit) begin
                    act = ACT_DATA_STALL;
                end else if (id_branch) begin
                    act = ACT_BR_ISSUE;
                end else begin
                    act = ACT_ADVANCE;
                end
            end
            ST_RESOLVE: begin
                act = ACT_BR_RESOLVE;
            end
            default: begin
                act = ACT_IDLE;
            end
        endcase
    end

    // Next state.
    always_comb begin
        state_d = ST_FLOW;
        unique case (act)
            ACT_BR_ISSUE:   state_d = ST_RESOLVE;
            ACT_IDLE,
            ACT_ADVANCE,
            ACT_DATA_STALL,
            ACT_BR_RESOLVE: state_d = ST_FLOW;
            default:        state_d = ST_FLOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        ctl   = '0;
        issue = 1'b0;
        if (!rst) begin
            unique case (act)
                ACT_IDLE: begin
                    ctl = '0;
                end
                ACT_ADVANCE: begin
                    issue = 1'b1;
                end
                ACT_DATA_STALL: begin
                    ctl.pc_hold     = 1'b1;
                    ctl.ifid_hold   = 1'b1;
                    ctl.idex_bubble = 1'b1;
                end
                ACT_BR_ISSUE: begin
                    issue            = 1'b1;
                    ctl.pc_hold      = 1'b1;
                    ctl.fetch_squash = 1'b1;
                end
                ACT_BR_RESOLVE: begin
                    ctl.pc_hold       = 1'b1;
                    ctl.fetch_squash  = 1'b1;
                    ctl.redirect_take = ex_taken;
                end
                default: begin
                    ctl = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
    parameter int REG_W     = 5,
    parameter int HAZ_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_src_a,
    input  logic             id_use_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_use_b,
    input  logic [REG_W-1:0] id_dst,
    input  logic             id_wr,
    input  logic             id_branch,
    input  logic             ex_taken,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             fetch_squash,
    output logic             redirect_take
);
    import hz_pkg::*;

    localparam int NUM_SRC = 2;

    logic [REG_W-1:0]   src_vec [NUM_SRC];
    logic [NUM_SRC-1:0] use_vec;
    logic [HAZ_DEPTH-1:0] trk_v;
    logic [REG_W-1:0]   trk_dst [HAZ_DEPTH];
    logic               dep_hit;
    logic               issue;
    logic               push_wr;
    hz_ctl_t            ctl;

    assign src_vec[0] = id_src_a;
    assign src_vec[1] = id_src_b;
    assign use_vec    = {id_use_b, id_use_a};
    assign push_wr    = id_wr && !id_branch;

    hz_stage_track #(
        .REG_W (REG_W),
        .DEPTH (HAZ_DEPTH)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .push     (issue),
        .push_dst (id_dst),
        .push_wr  (push_wr),
        .trk_v    (trk_v),
        .trk_dst  (trk_dst)
    );

    hz_dep_detect #(
        .REG_W   (REG_W),
        .DEPTH   (HAZ_DEPTH),
        .NUM_SRC (NUM_SRC)
    ) u_detect (
        .src     (src_vec),
        .use_src (use_vec),
        .trk_v   (trk_v),
        .trk_dst (trk_dst),
        .hit     (dep_hit)
    );

    hz_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .id_branch (id_branch),
        .dep_hit   (dep_hit),
        .ex_taken  (ex_taken),
        .ctl       (ctl),
        .issue     (issue)
    );

    assign pc_hold       = ctl.pc_hold;
    assign ifid_hold     = ctl.ifid_hold;
    assign idex_bubble   = ctl.idex_bubble;
    assign fetch_squash  = ctl.fetch_squash;
    assign redirect_take = ctl.redirect_take;

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             id_valid,
    input logic [REG_W-1:0] id_src_a,
    input logic             id_use_a,
    input logic [REG_W-1:0] id_src_b,
    input logic             id_use_b,
    input logic             id_branch,
    input logic             ex_taken,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             fetch_squash,
    input logic             redirect_take
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !(pc_hold || ifid_hold || idex_bubble || fetch_squash || redirect_take)); // R1

    AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (pc_hold && ifid_hold && !fetch_squash)); // R2

    AST_STALL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (idex_bubble && $past(idex_bubble)) |=> !idex_bubble); // R4

    AST_NO_SOURCE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        ((!id_use_a || id_src_a == '0) && (!id_use_b || id_src_b == '0)) |-> !idex_bubble); // R6

    AST_BRANCH_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_branch && !idex_bubble) |-> (fetch_squash && pc_hold && !ifid_hold)); // R7

    AST_FREEZE_TWO: assert property (@(posedge clk) disable iff (rst)
        (fetch_squash && !$past(fetch_squash)) |=> (fetch_squash && pc_hold)); // R8

    AST_REDIRECT_PLACE: assert property (@(posedge clk) disable iff (rst)
        redirect_take |-> (fetch_squash && ex_taken && $past(fetch_squash))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!id_valid && !fetch_squash) |-> !(pc_hold || ifid_hold || idex_bubble || redirect_take)); // R10

endmodule

bind hz_interlock hz_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_hz_interlock.sv
`timescale 1ns/1ps
module sim_hz_interlock;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          id_valid;
    logic [RW-1:0] id_src_a, id_src_b, id_dst;
    logic          id_use_a, id_use_b, id_wr, id_branch, ex_taken;
    logic          pc_hold, ifid_hold, idex_bubble, fetch_squash, redirect_take;

    hz_interlock #(.REG_W(RW), .HAZ_DEPTH(2)) u0 (
        .clk(clk), .rst(rst), .id_valid(id_valid),
        .id_src_a(id_src_a), .id_use_a(id_use_a),
        .id_src_b(id_src_b), .id_use_b(id_use_b),
        .id_dst(id_dst), .id_wr(id_wr), .id_branch(id_branch),
        .ex_taken(ex_taken), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .fetch_squash(fetch_squash),
        .redirect_take(redirect_take)
    );

    int checks = 0;
    int errors = 0;

    // Reference model: cycles until each register is readable, pending branch.
    int  ready [32];
    bit  br_ex;
    bit  pend_taken;
    bit  after_resolve;
    int  bubbles_seen;

    // Instruction word: [4:0] src a, [5] use a, [10:6] src b, [11] use b,
    // [16:12] dst, [17] writes, [18] branch, [19] taken.
    logic [19:0] q [$];

    function automatic logic [19:0] ins(int a, bit ua, int b, bit ub, int d, bit w, bit br, bit tk);
        logic [19:0] r;
        r = '0;
        r[4:0]   = a[4:0];
        r[5]     = ua;
        r[10:6]  = b[4:0];
        r[11]    = ub;
        r[16:12] = d[4:0];
        r[17]    = w;
        r[18]    = br;
        r[19]    = tk;
        return r;
    endfunction

    function automatic logic [19:0] op_imm(int d, int s);
        return ins(s, 1, 0, 0, d, 1, 0, 0);
    endfunction

    function automatic logic [19:0] op_rr(int d, int s1, int s2);
        return ins(s1, 1, s2, 1, d, 1, 0, 0);
    endfunction

    function automatic logic [19:0] op_bnz(int s, bit tk);
        return ins(s, 1, 0, 0, 0, 0, 1, tk);
    endfunction

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    function automatic bit model_hazard(logic [19:0] w);
        bit h;
        h = 1'b0;
        if (w[5]  && w[4:0]  != 0 && ready[w[4:0]]  > 0) h = 1'b1;
        if (w[11] && w[10:6] != 0 && ready[w[10:6]] > 0) h = 1'b1;
        return h;
    endfunction

    // One clock: drive at edge+1, sample at edge+4, update model at next edge.
    task automatic step(input logic [19:0] w, input bit v, input bit in_rst,
                        input string base_tag, output bit issued);
        bit e_pc, e_if, e_bub, e_sq, e_rd, haz;
        string tag;
        rst       = in_rst;
        id_valid  = v;
        id_src_a  = w[4:0];
        id_use_a  = w[5];
        id_src_b  = w[10:6];
        id_use_b  = w[11];
        id_dst    = w[16:12];
        id_wr     = w[17];
        id_branch = w[18];
        ex_taken  = br_ex ? pend_taken : 1'b1;
        {e_pc, e_if, e_bub, e_sq, e_rd} = '0;
        issued = 1'b0;
        haz = model_hazard(w);
        if (in_rst) begin
            tag = "R1";
        end else if (br_ex) begin
            tag = "R8";
            e_pc = 1; e_sq = 1; e_rd = pend_taken;
        end else if (v && haz) begin
            tag = w[18] ? "R9" : "R2";
            e_pc = 1; e_if = 1; e_bub = 1;
        end else if (v && w[18]) begin
            tag = "R7";
            e_pc = 1; e_sq = 1; issued = 1;
        end else if (!v) begin
            tag = "R10";
        end else begin
            tag = after_resolve ? "R11" : base_tag;
            issued = 1;
        end
        #3;
        chk(tag, "pc_hold",       pc_hold,       e_pc);
        chk(tag, "ifid_hold",     ifid_hold,     e_if);
        chk(tag, "idex_bubble",   idex_bubble,   e_bub);
        chk(tag, "fetch_squash",  fetch_squash,  e_sq);
        chk(tag, "redirect_take", redirect_take, e_rd);
        if (idex_bubble === 1'b1) bubbles_seen++;
        @(posedge clk);
        after_resolve = br_ex && !in_rst;
        if (in_rst) begin
            for (int r = 0; r < 32; r++) ready[r] = 0;
            br_ex = 0;
            after_resolve = 0;
        end else begin
            for (int r = 0; r < 32; r++) if (ready[r] > 0) ready[r]--;
            if (issued && w[17] && !w[18] && w[16:12] != 0) ready[w[16:12]] = 2;
            br_ex = issued && w[18];
            if (issued && w[18]) pend_taken = w[19];
        end
        #1;
    endtask

    // Junk presented in decode while a branch resolves: writes r6, reads r7.
    task automatic run(input string tag);
        bit iss;
        while (q.size() > 0 || br_ex) begin
            if (br_ex) begin
                step(op_imm(6, 7), 1'b1, 1'b0, tag, iss);
            end else begin
                step(q[0], 1'b1, 1'b0, tag, iss);
                if (iss) void'(q.pop_front());
            end
        end
    endtask

    task automatic do_reset(input int n);
        bit iss;
        for (int i = 0; i < n; i++) step(op_rr(6, 3, 2), 1'b1, 1'b1, "R1", iss);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit iss;
        for (int r = 0; r < 32; r++) ready[r] = 0;
        br_ex = 0; pend_taken = 0; after_resolve = 0; bubbles_seen = 0;
        rst = 1; id_valid = 0; id_src_a = 0; id_src_b = 0; id_dst = 0;
        id_use_a = 0; id_use_b = 0; id_wr = 0; id_branch = 0; ex_taken = 0;
        @(posedge clk); #1;
        do_reset(3);

        // R4: load then directly dependent add: two bubbles.
        bubbles_seen = 0;
        q.push_back(op_imm(3, 2));
        q.push_back(op_rr(3, 1, 3));
        run("R4");
        chk_int("R4", "bubbles back-to-back", bubbles_seen, 2);

        // R4: one independent instruction between: one bubble.
        bubbles_seen = 0;
        q.push_back(op_imm(2, 2));
        q.push_back(op_imm(11, 12));
        q.push_back(op_rr(13, 2, 14));
        run("R4");
        chk_int("R4", "bubbles one gap", bubbles_seen, 1);

        // R3: producer in writeback while consumer decodes: no stall.
        bubbles_seen = 0;
        q.push_back(op_imm(15, 16));
        q.push_back(op_imm(17, 18));
        q.push_back(op_imm(19, 20));
        q.push_back(op_rr(21, 15, 15));
        run("R3");
        chk_int("R3", "bubbles split cycle", bubbles_seen, 0);

        // R5: register zero as destination and as source.
        bubbles_seen = 0;
        q.push_back(op_imm(0, 4));
        q.push_back(op_rr(22, 0, 0));
        q.push_back(op_imm(23, 0));
        run("R5");
        chk_int("R5", "bubbles reg zero", bubbles_seen, 0);

        // R6: unused source fields naming a busy register.
        bubbles_seen = 0;
        q.push_back(op_imm(24, 1));
        q.push_back(ins(24, 0, 24, 0, 25, 1, 0, 0));
        run("R6");
        chk_int("R6", "bubbles unused sources", bubbles_seen, 0);

        // R7 R8 R9: three-iteration loop, 6 bubbles per iteration.
        bubbles_seen = 0;
        for (int it = 0; it < 3; it++) begin
            q.push_back(op_imm(2, 2));
            q.push_back(op_imm(3, 2));
            q.push_back(op_rr(3, 1, 3));
            q.push_back(op_imm(8, 8));
            q.push_back(op_imm(9, 9));
            q.push_back(op_bnz(9, it != 2));
        end
        run("R9");
        chk_int("R9", "bubbles loop", bubbles_seen, 18);

        // R8: not-taken branch, junk writer to r6 in resolve slot is ignored.
        bubbles_seen = 0;
        q.push_back(op_bnz(1, 1'b0));
        q.push_back(op_rr(10, 6, 7));
        run("R8");
        chk_int("R8", "bubbles after resolve junk", bubbles_seen, 0);

        // R10: idle decode with busy record and ex_taken high.
        q.push_back(op_imm(26, 1));
        run("R10");
        for (int i = 0; i < 3; i++) step(op_rr(27, 26, 26), 1'b0, 1'b0, "R10", iss);

        // R1: reset right after a producer issues clears its record.
        q.push_back(op_imm(28, 1));
        run("R1");
        do_reset(1);
        bubbles_seen = 0;
        q.push_back(op_rr(29, 28, 28));
        run("R1");
        chk_int("R1", "bubbles after reset", bubbles_seen, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule